// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Group

This block gathers 32 hardware event lines into one interrupt request. It sits on a simple memory-mapped register port. Each event line has a latched cause bit. A rising edge on the line sets that bit, and software can also set it by writing, for example to ring a doorbell. Each bit also has a mask bit that decides whether the cause reaches the interrupt output.

Software picks a clearing rule for each bit through a control register. With the control bit at 0, the cause bit is cleared by writing 1 to it. With the control bit at 1, the cause bit is cleared by reading it. The mask can be written as a whole word, or changed one bit at a time through a set port and a clear port, so there is no read-modify-write race. A masked-cause view returns only the causes that are not masked. The request output is a registered OR of that view.

Every register has the same bit for the same interrupt. Read data appears on `rdata` one cycle after `rd_en`, and is zero in cycles with no read.

Top module: `irq_cause_group`

## Requirements
- R1: The register index is `addr[4:2]`, with `addr[1:0]` and every bit above bit 4 equal to zero. The byte offsets are: 0x00 control, 0x04 cause, 0x08 masked cause, 0x0C cause set, 0x10 mask, 0x14 mask set, 0x18 mask clear. Read data is registered and returns one cycle after `rd_en`. Reads of 0x0C, 0x14, 0x18 and of any unmapped address return 0.
- R2: After reset, cause and control are all 0, mask is all 1 and `irq` is 0.
- R3: The control register reads back the last value written to it.
- R4: For a bit whose control bit is 0, writing 1 to that bit at 0x04 clears the cause bit. Writing 1 to that bit at 0x08 clears it only if the bit is unmasked. Writing 0 leaves the bit unchanged. Bits whose control bit is 1 ignore writes to the cause registers.
- R5: For a bit whose control bit is 1, a read of the cause register clears that bit if it read as 1. Bits whose control bit is 0 are not changed by reads.
- R6: A read at 0x08 returns cause AND NOT mask. The clear-on-read rule applies to the returned bits only, so masked causes survive a read at 0x08.
- R7: Writing 1 to a bit at 0x0C sets that cause bit. Writing 0 has no effect.
- R8: The mask at 0x10 can be read and written. Writing 1 at 0x14 sets that mask bit and writing 1 at 0x18 clears it. A 0 bit leaves the mask bit unchanged.
- R9: A 0-to-1 transition on `hw_evt[i]` sets cause bit i. An event line that stays high does not set the bit again after it has been cleared.
- R10: If a set (hardware edge or cause-set write) and a clear (write-1 or clear-on-read) hit the same bit in the same cycle, the bit ends at 1.
- R11: `irq` is the OR of cause AND NOT mask as it stood at the previous clock edge, so it changes one cycle after the cause or mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | N | Hardware event lines; a rising edge sets the matching cause bit |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` and `wdata` |
| addr | input | AW | Byte address within the group |
| wdata | input | N | Write data |
| rdata | output | N | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a collision on a single bit: a hardware rising edge that lands in the same clock cycle as a write-1 clear, or as a clear-on-read of that bit. The bench creates it by raising the event line at the same falling edge where it drives the clearing bus access, so both act at one rising edge. It then reads the cause register to show the bit survived. A second subtle case is a clear-on-read through the masked view while some causes are masked. The bench sets mixed causes under a partial mask, reads at 0x08, and then reads the raw cause to confirm which bits were consumed.

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hw_evt,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  rdata,
  output logic          irq
);
  localparam logic [2:0] IX_CTL  = 3'd0;
  localparam logic [2:0] IX_CAU  = 3'd1;
  localparam logic [2:0] IX_MCAU = 3'd2;
  localparam logic [2:0] IX_SET  = 3'd3;
  localparam logic [2:0] IX_MSK  = 3'd4;
  localparam logic [2:0] IX_MSET = 3'd5;
  localparam logic [2:0] IX_MCLR = 3'd6;

  logic [N-1:0] ctl_q, cause_q, mask_q, evt_q, rdata_q;
  logic         irq_q;
  logic [N-1:0] masked, rd_val, w1c, cor, set_bits, cause_d, mask_d;
  logic [2:0]   ix;
  logic         hit;

  assign ix     = addr[4:2];
  assign hit    = (addr[1:0] == 2'b00) && ((addr >> 5) == '0);
  assign masked = cause_q & ~mask_q;

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (ix)
        IX_CTL:  rd_val = ctl_q;
        IX_CAU:  rd_val = cause_q;
        IX_MCAU: rd_val = masked;
        IX_MSK:  rd_val = mask_q;
        default: rd_val = '0;
      endcase
    end
  end

  always_comb begin
    w1c = '0;
    if (wr_en && hit && ix == IX_CAU)  w1c = wdata & ~ctl_q;
    if (wr_en && hit && ix == IX_MCAU) w1c = wdata & ~ctl_q & ~mask_q;
  end

  assign cor      = (rd_en && hit && (ix == IX_CAU || ix == IX_MCAU)) ? (rd_val & ctl_q) : '0;
  assign set_bits = (hw_evt & ~evt_q) | ((wr_en && hit && ix == IX_SET) ? wdata : '0);
  assign cause_d  = (cause_q & ~(w1c | cor)) | set_bits;

  always_comb begin
    mask_d = mask_q;
    if (wr_en && hit) begin
      case (ix)
        IX_MSK:  mask_d = wdata;
        IX_MSET: mask_d = mask_q | wdata;
        IX_MCLR: mask_d = mask_q & ~wdata;
        default: mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cause_q <= '0;
      mask_q  <= '1;
      evt_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && hit && ix == IX_CTL) ctl_q <= wdata;
      cause_q <= cause_d;
      mask_q  <= mask_d;
      evt_q   <= hw_evt;
      rdata_q <= rd_en ? rd_val : '0;
      irq_q   <= |masked;
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

module irq_cause_group_chk #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  hw_evt,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [N-1:0]  wdata,
  input logic          irq,
  input logic [N-1:0]  ctl_q,
  input logic [N-1:0]  cause_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  evt_q
);
  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(cause_q & ~mask_q)));

  p_ctl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> ctl_q == $past(wdata));

  p_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12)) |=> (cause_q & $past(wdata)) == $past(wdata));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(20)) |=> (mask_q & $past(wdata)) == $past(wdata));

  p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(24)) |=> (mask_q & $past(wdata)) == '0);

  p_edge_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_evt & ~evt_q)) |=> (cause_q & $past(hw_evt & ~evt_q)) == $past(hw_evt & ~evt_q));
endmodule

bind irq_cause_group irq_cause_group_chk #(.N(N), .AW(AW)) u_chk (.*);

// File: tb/tb_irq_cause_group.sv
module tb_irq_cause_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_evt = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  irq_cause_group dut (.clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R2 irq", {31'b0, irq}, 32'h0);
    rd(5'h00, v); chk("R2 ctl", v, 32'h0);
    rd(5'h04, v); chk("R2 cause", v, 32'h0);
    rd(5'h10, v); chk("R2 mask", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctl;
    logic [31:0] v;
    wr(5'h00, 32'hA5A5_0F0F); rd(5'h00, v); chk("R3 ctl rw", v, 32'hA5A5_0F0F);
    wr(5'h00, 32'h0); rd(5'h00, v); chk("R3 ctl zero", v, 32'h0);
  endtask

  task automatic t_wo_reads;
    logic [31:0] v;
    wr(5'h0C, 32'h0000_0001);
    rd(5'h0C, v); chk("R1 set reads 0", v, 32'h0);
    rd(5'h14, v); chk("R1 mset reads 0", v, 32'h0);
    rd(5'h18, v); chk("R1 mclr reads 0", v, 32'h0);
    rd(5'h1C, v); chk("R1 unmapped reads 0", v, 32'h0);
    rd(5'h05, v); chk("R1 misaligned reads 0", v, 32'h0);
    wr(5'h04, 32'h0000_0001);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(5'h10, 32'h0000_FF00); rd(5'h10, v); chk("R8 mask rw", v, 32'h0000_FF00);
    wr(5'h14, 32'h0000_000F); rd(5'h10, v); chk("R8 mask set", v, 32'h0000_FF0F);
    wr(5'h18, 32'h0000_0F00); rd(5'h10, v); chk("R8 mask clear", v, 32'h0000_F00F);
    wr(5'h14, 32'h0); wr(5'h18, 32'h0); rd(5'h10, v); chk("R8 zero no effect", v, 32'h0000_F00F);
    wr(5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(5'h0C, 32'h0000_0011); rd(5'h04, v); chk("R7 sw set", v, 32'h0000_0011);
    rd(5'h04, v); chk("R5 w1c bits not read-cleared", v, 32'h0000_0011);
    wr(5'h04, 32'h0000_0001); rd(5'h04, v); chk("R4 w1c clear", v, 32'h0000_0010);
    wr(5'h04, 32'h0); rd(5'h04, v); chk("R4 write 0 keeps", v, 32'h0000_0010);
    wr(5'h08, 32'h0000_0010); rd(5'h04, v); chk("R4 masked-view write skips masked bit", v, 32'h0000_0010);
    wr(5'h04, 32'h0000_0010); rd(5'h04, v); chk("R4 w1c clear all", v, 32'h0);
  endtask

  task automatic t_cor;
    logic [31:0] v;
    wr(5'h00, 32'h0000_0300);
    wr(5'h0C, 32'h0000_0700);
    wr(5'h04, 32'h0000_0300); rd(5'h04, v); chk("R4 cor bits ignore write", v, 32'h0000_0700);
    rd(5'h04, v); chk("R5 cor second read", v, 32'h0000_0400);
    wr(5'h04, 32'h0000_0400); rd(5'h04, v); chk("R5 cleanup", v, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    wr(5'h00, 32'h0000_00FF);
    wr(5'h10, 32'hFFFF_FFF0);
    wr(5'h0C, 32'h0000_0033);
    rd(5'h08, v); chk("R6 masked view", v, 32'h0000_0003);
    rd(5'h04, v); chk("R6 masked bits survive", v, 32'h0000_0030);
    rd(5'h04, v); chk("R5 raw cor cleared", v, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(5'h0C, 32'h0000_0020);
    @(negedge clk); chk("R11 masked no irq", {31'b0, irq}, 32'h0);
    wr(5'h18, 32'h0000_0020);
    chk("R11 irq lags unmask", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R11 irq asserts", {31'b0, irq}, 32'h1);
    wr(5'h04, 32'h0000_0020);
    chk("R11 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk); chk("R11 irq drops", {31'b0, irq}, 32'h0);
    wr(5'h14, 32'h0000_0020);
  endtask

  task automatic t_hw;
    logic [31:0] v;
    @(negedge clk); hw_evt[7] = 1'b1;
    rd(5'h04, v); chk("R9 edge sets", v, 32'h0000_0080);
    wr(5'h04, 32'h0000_0080);
    rd(5'h04, v); chk("R9 held level no reset", v, 32'h0);
    @(negedge clk); hw_evt[7] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(5'h0C, 32'h0000_0100);
    @(negedge clk); hw_evt[8] = 1'b1; wr_en = 1'b1; addr = 5'h04; wdata = 32'h0000_0100;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    rd(5'h04, v); chk("R10 edge beats w1c", v, 32'h0000_0100);
    hw_evt[8] = 1'b0;
    wr(5'h04, 32'h0000_0100);
    wr(5'h00, 32'h0000_0200);
    wr(5'h0C, 32'h0000_0200);
    @(negedge clk); hw_evt[9] = 1'b1; rd_en = 1'b1; addr = 5'h04;
    @(negedge clk); rd_en = 1'b0; v = rdata;
    chk("R10 race read value", v, 32'h0000_0200);
    rd(5'h04, v); chk("R10 edge beats cor", v, 32'h0000_0200);
    rd(5'h04, v); chk("R10 then cor clears", v, 32'h0);
    hw_evt[9] = 1'b0;
    wr(5'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_wo_reads();
    t_mask();
    t_w1c();
    t_cor();
    t_masked();
    t_irq();
    t_hw();
    t_race();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule